// File: doc/BRIEF.md
# Wiper Position Register with Bus-Clocked Stepping

This block holds the volatile position of a 64-tap digital potentiometer wiper and drives the tap switches from it. The position is a 6-bit code. It is decoded into a registered, strictly one-hot, 64-line tap-enable vector. Code 00h closes the switch at the low end of the resistor string and code 3Fh closes the switch at the high end.

The position changes in four ways. A recall loads the stored power-up value. A direct write comes from the bus command decoder. A transfer copies one of four data-register values, chosen by a select field. The fourth way is single steps in streaming mode. The command decoder arms streaming mode once it has acknowledged the step instruction. From then on the block watches the serial clock and data lines itself. Each complete clock-high pulse moves the wiper one tap, and the data level during that pulse sets the direction. A start or stop condition on the bus ends the mode.

Top module: `wiper_pos_reg`

## Requirements
- R1: From the end of reset onward, `tap_sel` has exactly one bit set in every cycle.
- R2: `tap_sel` has bit k set one clock after `pos` becomes k. Code 0 sets bit 0, the low terminal, and code 63 sets bit 63, the high terminal.
- R3: A synchronous active-high `rst` sets `pos` to 0, sets `tap_sel` to bit 0 and clears `stream_active`.
- R4: When `recall_req` is high at a clock edge, `pos` takes `recall_val` at that edge. This source wins over every other update in the same cycle.
- R5: When `wr_en` is high and no recall is requested, `pos` takes `wr_val`. A write wins over a transfer and over a step in the same cycle.
- R6: When `xfr_en` is high and no recall or write is requested, `pos` takes data register `xfr_sel`. Register i occupies bits [6i+5:6i] of `dr_flat`.
- R7: A one-cycle `step_arm` pulse sets `stream_active` at the next clock edge.
- R8: While streaming, a clock-high pulse is counted when its falling edge is sampled, and `pos` changes two clocks after that falling edge. If SDA was 1 when SCL rose, `pos` goes up by one. If SDA was 0, `pos` goes down by one.
- R9: Steps saturate: an up step at 63 leaves 63, and a down step at 0 leaves 0.
- R10: Any change of SDA while SCL stays high ends streaming at the next edge, whether it is a start or a stop. The pulse it occurred in is not counted, and later pulses do not step until the mode is armed again.
- R11: SCL pulses while streaming is not active leave `pos` unchanged.
- R12: With no recall, write, transfer or pending step, `pos` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock level, already synchronised to `clk` |
| sda_in | input | 1 | Serial data level, already synchronised to `clk` |
| step_arm | input | 1 | One-cycle pulse that starts streaming mode |
| recall_req | input | 1 | Load the power-up value |
| recall_val | input | 6 | Power-up value (content of data register 0) |
| wr_en | input | 1 | Direct write request |
| wr_val | input | 6 | Direct write value |
| xfr_en | input | 1 | Transfer request from a data register |
| xfr_sel | input | 2 | Index of the source data register |
| dr_flat | input | 24 | Four data-register values, register i at [6i+5:6i] |
| pos | output | 6 | Current wiper position, for read-back |
| tap_sel | output | 64 | One-hot tap switch enables, registered |
| stream_active | output | 1 | Streaming mode is in progress |

## Verification
The properties assume that SCL and SDA never change in the same system-clock cycle. They also assume that a step arm is issued only while SCL is low. Under these assumptions every sampled SDA change during an SCL-high phase is a genuine start or stop. The bench drives the bus lines in separate ticks and holds each level for several clocks. It pulses the arm only after pulling SCL low. Requests from the command decoder are single-cycle pulses, except in the deliberate collision cases that test priority.

// File: rtl/wiper_pkg.sv
`timescale 1ns/1ps
package wiper_pkg;

    localparam int POS_W_DEF  = 6;
    localparam int NUM_DR_DEF = 4;

    typedef enum logic [2:0] {
        SRC_HOLD,
        SRC_RECALL,
        SRC_WRITE,
        SRC_XFR,
        SRC_STEP
    } upd_src_e;

    typedef struct packed {
        logic valid;
        logic up;
    } step_req_t;

    function automatic upd_src_e pick_source(input logic recall, input logic wr,
                                             input logic xfr, input logic step);
        if (recall)    return SRC_RECALL;
        else if (wr)   return SRC_WRITE;
        else if (xfr)  return SRC_XFR;
        else if (step) return SRC_STEP;
        else           return SRC_HOLD;
    endfunction

endpackage

// File: rtl/wiper_stream_step.sv
`timescale 1ns/1ps
module wiper_stream_step
    import wiper_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      arm,
    input  logic      scl,
    input  logic      sda,
    output step_req_t step,
    output logic      active
);
    logic scl_prev, sda_prev;
    logic pulse_open, pulse_dir;
    logic scl_rise, scl_fall, bus_cond;

    always_ff @(posedge clk) begin
        scl_prev <= scl;
        sda_prev <= sda;
    end

    assign scl_rise = scl & ~scl_prev;
    assign scl_fall = ~scl & scl_prev;
    assign bus_cond = scl & scl_prev & (sda ^ sda_prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= 1'b0;
            pulse_open <= 1'b0;
            pulse_dir  <= 1'b0;
            step       <= '0;
        end else begin
            step.valid <= active & pulse_open & scl_fall & ~bus_cond;
            step.up    <= pulse_dir;
            if (active & bus_cond)
                active <= 1'b0;
            else if (arm)
                active <= 1'b1;
            if (!active || bus_cond)
                pulse_open <= 1'b0;
            else if (scl_rise)
                pulse_open <= 1'b1;
            else if (scl_fall)
                pulse_open <= 1'b0;
            if (scl_rise)
                pulse_dir <= sda;
        end
    end
endmodule

// File: rtl/wiper_pos_core.sv
`timescale 1ns/1ps
module wiper_pos_core
    import wiper_pkg::*;
#(
    parameter int POS_W  = POS_W_DEF,
    parameter int NUM_DR = NUM_DR_DEF,
    localparam int SEL_W = (NUM_DR > 1) ? $clog2(NUM_DR) : 1
)(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    recall_req,
    input  logic [POS_W-1:0]        recall_val,
    input  logic                    wr_en,
    input  logic [POS_W-1:0]        wr_val,
    input  logic                    xfr_en,
    input  logic [SEL_W-1:0]        xfr_sel,
    input  logic [NUM_DR*POS_W-1:0] dr_flat,
    input  step_req_t               step,
    output logic [POS_W-1:0]        pos
);
    localparam logic [POS_W-1:0] POS_MAX = '1;
    localparam logic [POS_W-1:0] POS_MIN = '0;

    logic [POS_W-1:0] dr_arr [NUM_DR];
    logic [POS_W-1:0] xfr_val, step_val, pos_next;
    upd_src_e         src;

    for (genvar i = 0; i < NUM_DR; i++) begin : g_dr
        assign dr_arr[i] = dr_flat[i*POS_W +: POS_W];
    end

    assign xfr_val = dr_arr[xfr_sel];

    always_comb begin
        if (step.up)
            step_val = (pos == POS_MAX) ? pos : pos + 1'b1;
        else
            step_val = (pos == POS_MIN) ? pos : pos - 1'b1;
    end

    assign src = pick_source(recall_req, wr_en, xfr_en, step.valid);

    always_comb begin
        unique case (src)
            SRC_RECALL: pos_next = recall_val;
            SRC_WRITE:  pos_next = wr_val;
            SRC_XFR:    pos_next = xfr_val;
            SRC_STEP:   pos_next = step_val;
            default:    pos_next = pos;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pos <= '0;
        else     pos <= pos_next;
    end
endmodule

// File: rtl/wiper_tap_decode.sv
`timescale 1ns/1ps
module wiper_tap_decode #(
    parameter int POS_W = 6,
    localparam int NUM_TAPS = 1 << POS_W
)(
    input  logic                clk,
    input  logic                rst,
    input  logic [POS_W-1:0]    pos,
    output logic [NUM_TAPS-1:0] tap_sel
);
    localparam logic [NUM_TAPS-1:0] TAP_RST = NUM_TAPS'(1);

    logic [NUM_TAPS-1:0] hit;

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        localparam logic [POS_W-1:0] IDX = POS_W'(i);
        assign hit[i] = (pos == IDX);
    end

    always_ff @(posedge clk) begin
        if (rst) tap_sel <= TAP_RST;
        else     tap_sel <= hit;
    end
endmodule

// File: rtl/wiper_pos_reg.sv
`timescale 1ns/1ps
module wiper_pos_reg
    import wiper_pkg::*;
#(
    parameter int POS_W  = POS_W_DEF,
    parameter int NUM_DR = NUM_DR_DEF,
    localparam int SEL_W    = (NUM_DR > 1) ? $clog2(NUM_DR) : 1,
    localparam int NUM_TAPS = 1 << POS_W
)(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    scl_in,
    input  logic                    sda_in,
    input  logic                    step_arm,
    input  logic                    recall_req,
    input  logic [POS_W-1:0]        recall_val,
    input  logic                    wr_en,
    input  logic [POS_W-1:0]        wr_val,
    input  logic                    xfr_en,
    input  logic [SEL_W-1:0]        xfr_sel,
    input  logic [NUM_DR*POS_W-1:0] dr_flat,
    output logic [POS_W-1:0]        pos,
    output logic [NUM_TAPS-1:0]     tap_sel,
    output logic                    stream_active
);
    step_req_t step;
    logic      step_v, step_up;

    assign step_v  = step.valid;
    assign step_up = step.up;

    wiper_stream_step u_stream (
        .clk    (clk),
        .rst    (rst),
        .arm    (step_arm),
        .scl    (scl_in),
        .sda    (sda_in),
        .step   (step),
        .active (stream_active)
    );

    wiper_pos_core #(.POS_W(POS_W), .NUM_DR(NUM_DR)) u_core (
        .clk        (clk),
        .rst        (rst),
        .recall_req (recall_req),
        .recall_val (recall_val),
        .wr_en      (wr_en),
        .wr_val     (wr_val),
        .xfr_en     (xfr_en),
        .xfr_sel    (xfr_sel),
        .dr_flat    (dr_flat),
        .step       (step),
        .pos        (pos)
    );

    wiper_tap_decode #(.POS_W(POS_W)) u_decode (
        .clk     (clk),
        .rst     (rst),
        .pos     (pos),
        .tap_sel (tap_sel)
    );
endmodule

// File: rtl/wiper_pos_reg_chk.sv
`timescale 1ns/1ps
module wiper_pos_reg_chk #(
    parameter int POS_W = 6,
    localparam int NUM_TAPS = 1 << POS_W
)(
    input logic                clk,
    input logic                rst,
    input logic                scl_in,
    input logic                sda_in,
    input logic                recall_req,
    input logic [POS_W-1:0]    recall_val,
    input logic                wr_en,
    input logic [POS_W-1:0]    wr_val,
    input logic                xfr_en,
    input logic                step_v,
    input logic                step_up,
    input logic                stream_active,
    input logic [POS_W-1:0]    pos,
    input logic [NUM_TAPS-1:0] tap_sel
);
    localparam logic [POS_W-1:0]    PMAX = '1;
    localparam logic [NUM_TAPS-1:0] ONE  = NUM_TAPS'(1);

    logic no_load;
    assign no_load = !recall_req && !wr_en && !xfr_en;

    a_r1_tap_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(tap_sel) == 1);

    a_r2_tap_follows_pos: assert property (@(posedge clk) disable iff (rst)
        !rst |=> tap_sel == (ONE << $past(pos)));

    a_r4_recall_loads: assert property (@(posedge clk) disable iff (rst)
        recall_req |=> pos == $past(recall_val));

    a_r5_write_loads: assert property (@(posedge clk) disable iff (rst)
        wr_en && !recall_req |=> pos == $past(wr_val));

    a_r9_sat_high: assert property (@(posedge clk) disable iff (rst)
        no_load && step_v && step_up && pos == PMAX |=> pos == PMAX);

    a_r9_sat_low: assert property (@(posedge clk) disable iff (rst)
        no_load && step_v && !step_up && pos == '0 |=> pos == '0);

    a_r10_bus_cond_ends: assert property (@(posedge clk) disable iff (rst)
        stream_active && scl_in && $past(scl_in) && (sda_in != $past(sda_in))
        |=> !stream_active);

    a_r12_hold: assert property (@(posedge clk) disable iff (rst)
        no_load && !step_v |=> $stable(pos));
endmodule

bind wiper_pos_reg wiper_pos_reg_chk #(.POS_W(POS_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .scl_in        (scl_in),
    .sda_in        (sda_in),
    .recall_req    (recall_req),
    .recall_val    (recall_val),
    .wr_en         (wr_en),
    .wr_val        (wr_val),
    .xfr_en        (xfr_en),
    .step_v        (step_v),
    .step_up       (step_up),
    .stream_active (stream_active),
    .pos           (pos),
    .tap_sel       (tap_sel)
);

// File: tb/wiper_pos_reg_bench.sv
`timescale 1ns/1ps
module wiper_pos_reg_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_in = 1'b1, sda_in = 1'b1;
    logic        step_arm = 1'b0;
    logic        recall_req = 1'b0, wr_en = 1'b0, xfr_en = 1'b0;
    logic [5:0]  recall_val = '0, wr_val = '0;
    logic [1:0]  xfr_sel = '0;
    logic [23:0] dr_flat = '0;
    logic [5:0]  pos;
    logic [63:0] tap_sel;
    logic        stream_active;

    int vectors = 0, errors = 0;
    bit done = 0;

    // behavioural reference state
    int m_pos = 0, m_tap = 0;
    bit m_act = 0, m_open = 0, m_dir = 0, m_sv = 0, m_su = 0;
    bit m_scl_p = 1, m_sda_p = 1;

    always #10 clk = ~clk;

    wiper_pos_reg u_wiper_pos_reg (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .step_arm(step_arm), .recall_req(recall_req), .recall_val(recall_val),
        .wr_en(wr_en), .wr_val(wr_val), .xfr_en(xfr_en), .xfr_sel(xfr_sel),
        .dr_flat(dr_flat), .pos(pos), .tap_sel(tap_sel),
        .stream_active(stream_active)
    );

    task automatic check(input string tag, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_step();
        int  np, nt;
        bit  na, no, nd, nsv, nsu, rise, fall, cond;
        rise = scl_in && !m_scl_p;
        fall = !scl_in && m_scl_p;
        cond = scl_in && m_scl_p && (sda_in != m_sda_p);
        if (rst) begin
            np = 0; nt = 0; na = 0; no = 0; nd = 0; nsv = 0; nsu = 0;
        end else begin
            nt = m_pos;
            if (recall_req)  np = recall_val;
            else if (wr_en)  np = wr_val;
            else if (xfr_en) np = (dr_flat >> (6 * xfr_sel)) & 63;
            else if (m_sv)   np = m_su ? ((m_pos < 63) ? m_pos + 1 : 63)
                                       : ((m_pos > 0) ? m_pos - 1 : 0);
            else             np = m_pos;
            nsv = m_act && m_open && fall && !cond;
            nsu = m_dir;
            na  = (m_act && cond) ? 0 : (step_arm ? 1 : m_act);
            no  = (!m_act || cond) ? 0 : (rise ? 1 : (fall ? 0 : m_open));
            nd  = rise ? sda_in : m_dir;
        end
        m_pos = np; m_tap = nt; m_act = na; m_open = no; m_dir = nd;
        m_sv = nsv; m_su = nsu; m_scl_p = scl_in; m_sda_p = sda_in;
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_step();
            #2;
            if (!rst) begin
                check("R12 pos vs model", pos, m_pos);
                check("R2 tap vs model", (tap_sel == (64'd1 << m_tap)) ? 1 : 0, 1);
                check("R1 one-hot", $countones(tap_sel), 1);
                check("R7 stream flag vs model", stream_active, m_act);
            end
        end
    endtask

    task automatic bus_pulse(input bit level);
        sda_in = level; tick(2);
        scl_in = 1'b1;  tick(3);
        scl_in = 1'b0;  tick(3);
    endtask

    task automatic arm();
        step_arm = 1'b1; tick(1);
        step_arm = 1'b0; tick(1);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        dr_flat = {6'd9, 6'd48, 6'd33, 6'd5};
        tick(4);
        rst = 1'b0; tick(1);
        check("R3 reset pos", pos, 0);
        check("R3 reset tap bit0", tap_sel[0], 1);
        check("R3 reset stream", stream_active, 0);

        recall_val = 6'h15; recall_req = 1'b1; tick(1);
        recall_req = 1'b0; check("R4 recall", pos, 21); tick(1);

        wr_val = 6'h2A; wr_en = 1'b1; xfr_en = 1'b1; xfr_sel = 2'd1; tick(1);
        wr_en = 1'b0; xfr_en = 1'b0; check("R5 write over xfr", pos, 42); tick(1);

        xfr_en = 1'b1; xfr_sel = 2'd1; tick(1);
        xfr_en = 1'b0; check("R6 xfr reg1", pos, 33); tick(1);

        recall_req = 1'b1; wr_en = 1'b1; wr_val = 6'd7; recall_val = 6'd12; tick(1);
        recall_req = 1'b0; wr_en = 1'b0; check("R4 recall over write", pos, 12); tick(1);

        xfr_en = 1'b1; xfr_sel = 2'd2; tick(1);
        xfr_en = 1'b0; check("R6 xfr reg2", pos, 48); tick(1);

        scl_in = 1'b0; tick(2);
        bus_pulse(1); bus_pulse(0); bus_pulse(1);
        check("R11 no step when idle", pos, 48);

        arm();
        check("R7 stream armed", stream_active, 1);
        bus_pulse(1); bus_pulse(1); bus_pulse(1);
        check("R8 three up", pos, 51);
        bus_pulse(0); bus_pulse(0);
        check("R8 two down", pos, 49);

        wr_val = 6'd60; wr_en = 1'b1; tick(1); wr_en = 1'b0; tick(1);
        for (int k = 0; k < 5; k++) bus_pulse(1);
        check("R9 saturate high", pos, 63);
        check("R2 high terminal bit63", tap_sel[63], 1);

        wr_val = 6'd1; wr_en = 1'b1; tick(1); wr_en = 1'b0; tick(1);
        for (int k = 0; k < 3; k++) bus_pulse(0);
        check("R9 saturate low", pos, 0);
        check("R2 low terminal bit0", tap_sel[0], 1);

        wr_val = 6'd30; wr_en = 1'b1; tick(1); wr_en = 1'b0; tick(1);
        sda_in = 1'b0; tick(2);
        scl_in = 1'b1; tick(2);
        sda_in = 1'b1; tick(3);
        check("R10 stop ends stream", stream_active, 0);
        check("R10 stop pulse not counted", pos, 30);
        scl_in = 1'b0; tick(2);
        bus_pulse(1);
        check("R10 no step after stop", pos, 30);

        arm();
        sda_in = 1'b1; tick(2);
        scl_in = 1'b1; tick(2);
        sda_in = 1'b0; tick(3);
        check("R10 start ends stream", stream_active, 0);
        check("R10 start pulse not counted", pos, 30);
        scl_in = 1'b0; tick(2);
        bus_pulse(0);
        check("R10 no step after start", pos, 30);

        tick(10);
        check("R12 idle hold", pos, 30);

        rst = 1'b1; tick(2); rst = 1'b0; tick(1);
        check("R3 reset again", pos, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule